// File: doc/BRIEF.md
# Byte/Word Integer ALU with Status Flags

This block is the integer arithmetic and logic unit of a 16-bit processor datapath. It is purely combinational. A 3-bit operation code, a size select and two operands go in. The sized result, a write-back enable and six status flags (carry, parity, auxiliary carry, zero, sign, overflow) come out in the same cycle. The register-operand and immediate-operand instruction groups share one operation code, so the decoder upstream passes that field straight through.

The unit covers eight operations: four additive (add, add with carry, subtract, subtract with borrow), three bitwise (and, or, exclusive-or), and compare. Compare is a subtract whose result must not be committed. In byte mode only the low eight bits of each operand take part, and every flag is taken at the byte width. Word mode uses all sixteen bits.

Top module: `alu16_core`

## Requirements
- R1: The operation code maps 0 to add, 1 to or, 2 to add-with-carry, 3 to subtract-with-borrow, 4 to and, 5 to subtract, 6 to exclusive-or and 7 to compare. Add returns the sum of the sized operands, truncated to the chosen size.
- R2: Add-with-carry (code 2) returns a + b + carry_in at the chosen size.
- R3: Subtract (code 5) returns a - b, and subtract-with-borrow (code 3) returns a - b - carry_in, each at the chosen size.
- R4: Compare (code 7) produces exactly the flags of subtract on the same operands, with wb_en_o low. wb_en_o is high for the other seven codes.
- R5: For additive codes cf_o is the carry out of the sized top bit. For subtractive codes (3, 5, 7) cf_o is set when the unsigned minuend is less than the subtrahend plus the borrow-in.
- R6: af_o is the carry out of bit 3 for additive codes and the borrow out of bit 3 for subtractive codes.
- R7: of_o is set on signed overflow at the chosen size: same-sign addends whose sum has the other sign, or a minuend and subtrahend of opposite sign whose difference differs in sign from the minuend.
- R8: sf_o is the top bit of the sized result and zf_o is set when the sized result is zero. pf_o is set when bits 7..0 of the result hold an even number of ones, in both sizes.
- R9: And, or and exclusive-or return the bitwise result and force cf_o, of_o and af_o to 0.
- R10: With word_mode low, bits 15..8 of both operands are ignored and bits 15..8 of res_o are 0.
- R11: carry_in affects only codes 2 and 3. It has no effect on res_o or any flag for the other six codes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 3 | Operation code (see R1) |
| word_mode | input | 1 | 1 selects 16-bit operation, 0 selects 8-bit |
| src_a | input | 16 | Destination/first operand |
| src_b | input | 16 | Source/second operand |
| carry_in | input | 1 | Incoming carry or borrow flag |
| res_o | output | 16 | Sized result, upper byte 0 in byte mode |
| wb_en_o | output | 1 | Result should be written back |
| cf_o | output | 1 | Carry / borrow flag |
| pf_o | output | 1 | Even parity of low result byte |
| af_o | output | 1 | Nibble carry / borrow flag |
| zf_o | output | 1 | Zero flag |
| sf_o | output | 1 | Sign flag |
| of_o | output | 1 | Signed overflow flag |

## Verification
The bench builds the unit with its default widths: a 16-bit word, an 8-bit narrow size and a 4-bit nibble. That places the carry-out taps at bits 8 and 16 and the auxiliary tap at bit 4. Directed cases drive each tap across its boundary in both sizes: 0x7F+1 and 0x80-1 at byte size, 0xFFFF+1 and 0-0-borrow at word size. Garbage is placed in the upper operand bytes during byte operations, and carry_in is toggled under codes that must ignore it. A few hundred random vectors then cover all eight codes at both sizes against a reference model built on wide integer arithmetic.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_OR  = 3'd1,
    OP_ADC = 3'd2,
    OP_SBB = 3'd3,
    OP_AND = 3'd4,
    OP_SUB = 3'd5,
    OP_XOR = 3'd6,
    OP_CMP = 3'd7
  } alu_op_e;

  typedef struct packed {
    logic of;
    logic sf;
    logic zf;
    logic af;
    logic pf;
    logic cf;
  } alu_flags_t;

endpackage

// File: rtl/alu16_decode.sv
module alu16_decode
  import alu16_pkg::*;
(
  input  alu_op_e op,
  output logic    is_sub,
  output logic    is_logic,
  output logic    use_cin,
  output logic    wb_en
);

  always_comb begin
    is_sub   = 1'b0;
    is_logic = 1'b0;
    use_cin  = 1'b0;
    wb_en    = 1'b1;
    unique case (op)
      OP_ADD: ;
      OP_ADC: use_cin = 1'b1;
      OP_SUB: is_sub = 1'b1;
      OP_SBB: begin
        is_sub  = 1'b1;
        use_cin = 1'b1;
      end
      OP_CMP: begin
        is_sub = 1'b1;
        wb_en  = 1'b0;
      end
      OP_AND, OP_OR, OP_XOR: is_logic = 1'b1;
      default: ;
    endcase
  end

endmodule

// File: rtl/alu16_addsub.sv
module alu16_addsub #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  input  logic         cin_eff,
  output logic [W-1:0] sum,
  output logic [W:0]   carry
);

  logic [W-1:0] b_eff;

  // Subtraction as a + ~b + ~borrow: carry out high means no borrow.
  assign b_eff = sub ? ~b : b;

  always_comb begin
    carry[0] = sub ? ~cin_eff : cin_eff;
    for (int i = 0; i < W; i++) begin
      sum[i]     = a[i] ^ b_eff[i] ^ carry[i];
      carry[i+1] = (a[i] & b_eff[i]) | (carry[i] & (a[i] ^ b_eff[i]));
    end
  end

endmodule

// File: rtl/alu16_logic.sv
module alu16_logic
  import alu16_pkg::*;
#(
  parameter int W = 16
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);

  always_comb begin
    unique case (op)
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      default: y = '0;
    endcase
  end

endmodule

// File: rtl/alu16_flags.sv
module alu16_flags
  import alu16_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NARROW_W = 8,
  parameter int NIBBLE_W = 4
) (
  input  logic [DATA_W-1:0] raw,
  input  logic [DATA_W:0]   carry,
  input  logic              word_mode,
  input  logic              is_sub,
  input  logic              is_logic,
  output logic [DATA_W-1:0] res,
  output alu_flags_t        flags
);

  localparam int WIDE_MSB   = DATA_W - 1;
  localparam int NARROW_MSB = NARROW_W - 1;

  logic cout;
  logic cin_msb;

  always_comb begin
    if (word_mode) begin
      res     = raw;
      cout    = carry[WIDE_MSB+1];
      cin_msb = carry[WIDE_MSB];
      flags.sf = raw[WIDE_MSB];
    end else begin
      res     = {{(DATA_W-NARROW_W){1'b0}}, raw[NARROW_MSB:0]};
      cout    = carry[NARROW_MSB+1];
      cin_msb = carry[NARROW_MSB];
      flags.sf = raw[NARROW_MSB];
    end
    flags.zf = (res == '0);
    flags.pf = ~^res[NARROW_MSB:0];
    flags.cf = is_logic ? 1'b0 : (cout ^ is_sub);
    flags.af = is_logic ? 1'b0 : (carry[NIBBLE_W] ^ is_sub);
    flags.of = is_logic ? 1'b0 : (cout ^ cin_msb);
  end

  always_comb begin
    if (!$isunknown({raw, carry, word_mode, is_sub, is_logic})) begin
      assert_zero_sign_R8: assert (!(flags.zf && flags.sf))
        else $error("zero and sign flags both set");
      assert_zero_parity_R8: assert (!flags.zf || flags.pf)
        else $error("zero result without even parity");
    end
  end

endmodule

// File: rtl/alu16_core.sv
module alu16_core
  import alu16_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NARROW_W = 8,
  parameter int NIBBLE_W = 4
) (
  input  logic [2:0]        op_sel,
  input  logic              word_mode,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic              carry_in,
  output logic [DATA_W-1:0] res_o,
  output logic              wb_en_o,
  output logic              cf_o,
  output logic              pf_o,
  output logic              af_o,
  output logic              zf_o,
  output logic              sf_o,
  output logic              of_o
);

  localparam int UPPER_W = DATA_W - NARROW_W;

  alu_op_e           op;
  logic              is_sub, is_logic, use_cin, wb_en;
  logic [DATA_W-1:0] a_sz, b_sz;
  logic [DATA_W-1:0] arith_y, logic_y, raw_y;
  logic [DATA_W:0]   carry;
  alu_flags_t        flags;

  assign op = alu_op_e'(op_sel);

  // Operand sizing happens once, before both datapaths.
  assign a_sz = word_mode ? src_a : {{UPPER_W{1'b0}}, src_a[NARROW_W-1:0]};
  assign b_sz = word_mode ? src_b : {{UPPER_W{1'b0}}, src_b[NARROW_W-1:0]};

  alu16_decode u_dec (
    .op       (op),
    .is_sub   (is_sub),
    .is_logic (is_logic),
    .use_cin  (use_cin),
    .wb_en    (wb_en)
  );

  alu16_addsub #(.W(DATA_W)) u_addsub (
    .a       (a_sz),
    .b       (b_sz),
    .sub     (is_sub),
    .cin_eff (use_cin & carry_in),
    .sum     (arith_y),
    .carry   (carry)
  );

  alu16_logic #(.W(DATA_W)) u_logic (
    .op (op),
    .a  (a_sz),
    .b  (b_sz),
    .y  (logic_y)
  );

  assign raw_y = is_logic ? logic_y : arith_y;

  alu16_flags #(
    .DATA_W   (DATA_W),
    .NARROW_W (NARROW_W),
    .NIBBLE_W (NIBBLE_W)
  ) u_flags (
    .raw       (raw_y),
    .carry     (carry),
    .word_mode (word_mode),
    .is_sub    (is_sub),
    .is_logic  (is_logic),
    .res       (res_o),
    .flags     (flags)
  );

  assign wb_en_o = wb_en;
  assign cf_o    = flags.cf;
  assign pf_o    = flags.pf;
  assign af_o    = flags.af;
  assign zf_o    = flags.zf;
  assign sf_o    = flags.sf;
  assign of_o    = flags.of;

  always_comb begin
    if (!$isunknown({op_sel, word_mode, src_a, src_b, carry_in})) begin
      if ((op == OP_ADD) && cf_o)
        assert_add_wrap_R5: assert (res_o < a_sz)
          else $error("add carry without wrap");
      if ((op == OP_SUB || op == OP_CMP) && !cf_o)
        assert_sub_noborrow_R5: assert (res_o <= a_sz)
          else $error("difference above minuend without borrow");
      if (is_logic)
        assert_logic_subset_R9: assert ((res_o & ~(a_sz | b_sz)) == '0)
          else $error("logic result has bit outside operands");
      if (!word_mode)
        assert_byte_upper_R10: assert (res_o[DATA_W-1:NARROW_W] == '0)
          else $error("upper byte set in byte mode");
      if (op == OP_CMP)
        assert_cmp_nowrite_R4: assert (!wb_en_o)
          else $error("compare requests write-back");
    end
  end

endmodule

// File: tb/alu16_core_tb.sv
module alu16_core_tb_top;

  logic        clk;
  logic [2:0]  op_sel;
  logic        word_mode;
  logic [15:0] src_a, src_b;
  logic        carry_in;
  logic [15:0] res_o;
  logic        wb_en_o, cf_o, pf_o, af_o, zf_o, sf_o, of_o;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit done     = 0;

  logic [22:0] exp_q[$];
  string       tag_q[$];

  alu16_core dut_i (
    .op_sel    (op_sel),
    .word_mode (word_mode),
    .src_a     (src_a),
    .src_b     (src_b),
    .carry_in  (carry_in),
    .res_o     (res_o),
    .wb_en_o   (wb_en_o),
    .cf_o      (cf_o),
    .pf_o      (pf_o),
    .af_o      (af_o),
    .zf_o      (zf_o),
    .sf_o      (sf_o),
    .of_o      (of_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Reference model: {wr, of, sf, zf, af, pf, cf, result}
  function automatic logic [22:0] model(input logic [2:0] op, input logic w,
                                        input logic [15:0] a, input logic [15:0] b,
                                        input logic ci);
    logic [15:0] mask, A, B, r;
    logic [16:0] full;
    logic        c, cf, af, of, sf, zf, pf;
    int          msb;
    mask = w ? 16'hFFFF : 16'h00FF;
    msb  = w ? 15 : 7;
    A = a & mask;
    B = b & mask;
    cf = 0; af = 0; of = 0;
    case (op)
      3'd0, 3'd2: begin
        c    = (op == 3'd2) ? ci : 1'b0;
        full = {1'b0, A} + {1'b0, B} + {16'b0, c};
        r    = full[15:0] & mask;
        cf   = w ? full[16] : full[8];
        af   = ({1'b0, A[3:0]} + {1'b0, B[3:0]} + {4'b0, c}) > 5'd15;
        of   = (A[msb] == B[msb]) && (r[msb] != A[msb]);
      end
      3'd3, 3'd5, 3'd7: begin
        c  = (op == 3'd3) ? ci : 1'b0;
        r  = (A - B - {15'b0, c}) & mask;
        cf = {1'b0, A} < ({1'b0, B} + {16'b0, c});
        af = {1'b0, A[3:0]} < ({1'b0, B[3:0]} + {4'b0, c});
        of = (A[msb] != B[msb]) && (r[msb] != A[msb]);
      end
      3'd1: r = A | B;
      3'd4: r = A & B;
      default: r = A ^ B;
    endcase
    sf = r[msb];
    zf = (r == 16'h0);
    pf = ~^r[7:0];
    return {op != 3'd7, of, sf, zf, af, pf, cf, r};
  endfunction

  task automatic drive(input logic [2:0] op, input logic w, input logic [15:0] a,
                       input logic [15:0] b, input logic ci, input string tag);
    @(posedge clk);
    #1;
    op_sel    = op;
    word_mode = w;
    src_a     = a;
    src_b     = b;
    carry_in  = ci;
    exp_q.push_back(model(op, w, a, b, ci));
    tag_q.push_back(tag);
  endtask

  // Monitor: samples at the falling edge, away from driver activity.
  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        logic [22:0] exp_v, act_v;
        string       tg;
        exp_v = exp_q.pop_front();
        tg    = tag_q.pop_front();
        act_v = {wb_en_o, of_o, sf_o, zf_o, af_o, pf_o, cf_o, res_o};
        n_checks++;
        if (act_v !== exp_v) begin
          n_fail++;
          $display("FAIL %s: op=%0d w=%0b a=%h b=%h ci=%0b actual {wr,of,sf,zf,af,pf,cf,res}=%b_%h expected %b_%h",
                   tg, op_sel, word_mode, src_a, src_b, carry_in,
                   act_v[22:16], act_v[15:0], exp_v[22:16], exp_v[15:0]);
        end
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000 && !done) begin
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual cycles=%0d expected fewer than 20000", cycles);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
      end
    end
  end

  initial begin
    op_sel = 3'd0; word_mode = 1'b0; src_a = '0; src_b = '0; carry_in = 1'b0;
    // Idle state with zero inputs: R8
    drive(3'd1, 1'b1, 16'h0000, 16'h0000, 1'b0, "R8 zero inputs");
    // R1 add, byte size with upper garbage (R10)
    drive(3'd0, 1'b0, 16'hAB12, 16'hCD34, 1'b0, "R1 add byte");
    drive(3'd0, 1'b0, 16'h55FF, 16'hAA01, 1'b0, "R10 byte wrap upper ignored");
    drive(3'd0, 1'b1, 16'hFFFF, 16'h0001, 1'b0, "R5 word carry out");
    // R7 signed overflow at both sizes
    drive(3'd0, 1'b0, 16'h007F, 16'h0001, 1'b0, "R7 byte add overflow");
    drive(3'd0, 1'b1, 16'h7FFF, 16'h0001, 1'b0, "R7 word add overflow");
    drive(3'd5, 1'b0, 16'h0080, 16'h0001, 1'b0, "R7 byte sub overflow");
    // R2 add with carry
    drive(3'd2, 1'b0, 16'h00FE, 16'h0001, 1'b1, "R2 adc to zero");
    drive(3'd2, 1'b1, 16'h1234, 16'h0FFF, 1'b1, "R2 adc word");
    // R3 subtract and subtract with borrow
    drive(3'd5, 1'b1, 16'h1000, 16'h0001, 1'b0, "R3 sub word");
    drive(3'd3, 1'b1, 16'h0000, 16'h0000, 1'b1, "R3 sbb borrow wrap");
    drive(3'd3, 1'b0, 16'h0005, 16'h0005, 1'b1, "R5 sbb equal with borrow");
    // R6 nibble carry / borrow
    drive(3'd0, 1'b0, 16'h000F, 16'h0001, 1'b0, "R6 nibble carry");
    drive(3'd5, 1'b0, 16'h0010, 16'h0001, 1'b0, "R6 nibble borrow");
    // R4 compare
    drive(3'd7, 1'b1, 16'h4242, 16'h4242, 1'b0, "R4 cmp equal");
    drive(3'd7, 1'b0, 16'h0003, 16'h0009, 1'b1, "R4 cmp below");
    // R9 logic ops with carry pending
    drive(3'd4, 1'b1, 16'hF0F0, 16'hFF00, 1'b1, "R9 and");
    drive(3'd1, 1'b0, 16'h1280, 16'h3401, 1'b1, "R9 or byte");
    drive(3'd6, 1'b1, 16'hFFFF, 16'h8001, 1'b0, "R9 xor");
    // R8 parity uses low byte only
    drive(3'd6, 1'b1, 16'h0100, 16'h0000, 1'b0, "R8 parity low byte");
    // R11 carry_in ignored outside adc/sbb
    drive(3'd0, 1'b0, 16'h0010, 16'h0020, 1'b1, "R11 add ignores cin");
    drive(3'd5, 1'b1, 16'h0100, 16'h0001, 1'b1, "R11 sub ignores cin");
    drive(3'd7, 1'b1, 16'h0001, 16'h0001, 1'b1, "R11 cmp ignores cin");
    for (int i = 0; i < 400; i++) begin
      drive(3'($urandom), 1'($urandom), 16'($urandom), 16'($urandom), 1'($urandom),
            "R1 random");
    end
    @(posedge clk);
    @(posedge clk);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule